// File: doc/BRIEF.md
# Long-Press Restart Timer

This block watches an active-low power button, sampled on the 32.768 kHz always-on clock. When the button is held long enough and the feature is enabled, it orders a full restart. In one cycle it pulses three strobes: power-down, charger-disable and register-clear. It then holds the system off for as long as the button remains held. On the first sample after the button is released, it pulses a power-up strobe. The time spent off therefore equals the part of the hold that ran past the threshold. At the default threshold of 393216 ticks (12 s), a 12.1 s hold gives roughly 0.1 s off.

Presses shorter than the threshold are not treated as a restart. They reach the rest of the chip as ordinary button activity through a synchronized pass-through output. The enable bit is active-low, so the feature runs while it is 0. The bit is a small register that the chip writes through a write strobe. Its reset value is a parameter so that each product variant can pick its own default. A restart also returns this bit to that default.

Top module: `longpress_restart`

## Requirements
- R1: While `rst_n` is low, all four strobes are 0 and `btn_pass_n` is 1.
- R2: While the stored disable bit is 1, no hold of any length produces a power-down, charger-disable or register-clear strobe.
- R3: After reset, the stored disable bit equals parameter `OFF_AT_RESET`. When `cfg_we` is 1 at a clock edge, the bit takes `cfg_off`.
- R4: A restart fires on the clock edge that takes the `HOLD_TICKS`-th consecutive pressed sample while the feature is enabled. `pwr_down`, `chg_off` and `reg_clr` are then 1 together for exactly the one cycle after that edge.
- R5: A released sample before the threshold clears the hold count. Two presses of `HOLD_TICKS-1` samples each, separated by one released sample, produce no restart.
- R6: After a restart, `pwr_up` is 1 for exactly one cycle, on the cycle after the first released sample. A hold of `HOLD_TICKS+k` samples spaces the power-down and power-up pulses k+1 cycles apart.
- R7: From a restart until its `pwr_up` pulse, no further restart fires, however long the button is held. A write to the disable bit in that interval does not prevent the `pwr_up` pulse.
- R8: `btn_pass_n` is the synchronized button level (0 = pressed), except that it reads 1 while the system is held off after a restart.
- R9: The button passes through `SYNC_STAGES` flip-flops. A change on `btn_n` reaches `btn_pass_n` after exactly `SYNC_STAGES` clock edges.
- R10: The edge that fires a restart loads `OFF_AT_RESET` into the disable bit, and this takes priority over a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 32.768 kHz always-on clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| btn_n | input | 1 | Power button level, 0 = pressed |
| cfg_we | input | 1 | Write strobe for the disable bit |
| cfg_off | input | 1 | Value written to the disable bit (0 = feature enabled) |
| pwr_down | output | 1 | One-cycle power-down request |
| chg_off | output | 1 | One-cycle charger-disable request |
| reg_clr | output | 1 | One-cycle request to clear all registers |
| pwr_up | output | 1 | One-cycle power-up request after release |
| btn_pass_n | output | 1 | Synchronized button for ordinary use, forced to 1 while held off |

## Verification
A hold count that drifts, or fails to clear on release, moves the power-down pulse off the cycle the bench model predicts. A missing clear can also create a restart from two short presses, so the error shows at the strobes on the very edge where the threshold is wrongly reached or missed. A wrong off-state flag shows at once on `btn_pass_n`, which the bench compares against the model on every clock. It also shows as a misplaced or missing `pwr_up` pulse. A wrong disable bit shows up at the next long hold, as a restart that should not occur or one that fails to occur.

// File: rtl/longpress_pkg.sv
package longpress_pkg;
   typedef enum logic [0:0] {
      ST_ARMED = 1'b0,
      ST_HELD_OFF = 1'b1
   } lp_state_e;

   function automatic int unsigned lp_cnt_width(input int unsigned limit);
      return (limit < 2) ? 1 : $clog2(limit);
   endfunction
endpackage

// File: rtl/lp_btn_sync.sv
module lp_btn_sync #(
   parameter int SYNC_STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic btn_n,
   output logic pressed
);
   logic [SYNC_STAGES-1:0] pipe_q;

   for (genvar i = 0; i < SYNC_STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe_q[0] <= 1'b0;
            else        pipe_q[0] <= ~btn_n;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) pipe_q[i] <= 1'b0;
            else        pipe_q[i] <= pipe_q[i-1];
         end
      end
   end

   assign pressed = pipe_q[SYNC_STAGES-1];
endmodule

// File: rtl/lp_hold_counter.sv
module lp_hold_counter #(
   parameter int HOLD_TICKS = 393216,
   localparam int CNT_W = longpress_pkg::lp_cnt_width(HOLD_TICKS)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             inc,
   input  logic             clr,
   output logic [CNT_W-1:0] cnt,
   output logic             at_limit
);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(HOLD_TICKS - 1);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   cnt_q <= '0;
      else if (clr) cnt_q <= '0;
      else if (inc) cnt_q <= cnt_q + 1'b1;
   end

   assign cnt      = cnt_q;
   assign at_limit = (cnt_q == LAST);
endmodule

// File: rtl/lp_restart_fsm.sv
module lp_restart_fsm
   import longpress_pkg::*;
#(
   parameter bit OFF_AT_RESET = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pressed,
   input  logic at_limit,
   input  logic cfg_we,
   input  logic cfg_off,
   output logic cnt_inc,
   output logic cnt_clr,
   output logic in_off,
   output logic fire_pulse,
   output logic up_pulse
);
   lp_state_e state_q, state_d;
   logic      off_bit_q;
   logic      fire_d, up_d;
   logic      fire_q, up_q;

   always_comb begin
      state_d = state_q;
      cnt_inc = 1'b0;
      cnt_clr = 1'b0;
      fire_d  = 1'b0;
      up_d    = 1'b0;
      unique case (state_q)
         ST_ARMED: begin
            if (pressed && !off_bit_q) begin
               if (at_limit) begin
                  fire_d  = 1'b1;
                  cnt_clr = 1'b1;
                  state_d = ST_HELD_OFF;
               end else begin
                  cnt_inc = 1'b1;
               end
            end else begin
               cnt_clr = 1'b1;
            end
         end
         ST_HELD_OFF: begin
            if (!pressed) begin
               up_d    = 1'b1;
               state_d = ST_ARMED;
            end
         end
         default: state_d = ST_ARMED;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_ARMED;
         fire_q  <= 1'b0;
         up_q    <= 1'b0;
      end else begin
         state_q <= state_d;
         fire_q  <= fire_d;
         up_q    <= up_d;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      off_bit_q <= OFF_AT_RESET;
      else if (fire_d) off_bit_q <= OFF_AT_RESET;
      else if (cfg_we) off_bit_q <= cfg_off;
   end

   assign in_off     = (state_q == ST_HELD_OFF);
   assign fire_pulse = fire_q;
   assign up_pulse   = up_q;
endmodule

// File: rtl/longpress_restart.sv
module longpress_restart #(
   parameter int HOLD_TICKS   = 393216,
   parameter int SYNC_STAGES  = 2,
   parameter bit OFF_AT_RESET = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic btn_n,
   input  logic cfg_we,
   input  logic cfg_off,
   output logic pwr_down,
   output logic chg_off,
   output logic reg_clr,
   output logic pwr_up,
   output logic btn_pass_n
);
   localparam int CNT_W = longpress_pkg::lp_cnt_width(HOLD_TICKS);

   if (HOLD_TICKS < 2) begin : g_bad_hold
      $error("HOLD_TICKS must be at least 2");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end

   logic             pressed;
   logic             cnt_inc, cnt_clr, at_limit;
   logic [CNT_W-1:0] hold_cnt;
   logic             in_off;
   logic             fire_pulse, up_pulse;

   lp_btn_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .btn_n   (btn_n),
      .pressed (pressed)
   );

   lp_hold_counter #(.HOLD_TICKS(HOLD_TICKS)) u_cnt (
      .clk      (clk),
      .rst_n    (rst_n),
      .inc      (cnt_inc),
      .clr      (cnt_clr),
      .cnt      (hold_cnt),
      .at_limit (at_limit)
   );

   lp_restart_fsm #(.OFF_AT_RESET(OFF_AT_RESET)) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .pressed    (pressed),
      .at_limit   (at_limit),
      .cfg_we     (cfg_we),
      .cfg_off    (cfg_off),
      .cnt_inc    (cnt_inc),
      .cnt_clr    (cnt_clr),
      .in_off     (in_off),
      .fire_pulse (fire_pulse),
      .up_pulse   (up_pulse)
   );

   assign pwr_down   = fire_pulse;
   assign chg_off    = fire_pulse;
   assign reg_clr    = fire_pulse;
   assign pwr_up     = up_pulse;
   assign btn_pass_n = ~pressed | in_off;
endmodule

// File: rtl/longpress_restart_chk.sv
module longpress_restart_chk #(
   parameter int HOLD_TICKS = 393216,
   localparam int CNT_W = longpress_pkg::lp_cnt_width(HOLD_TICKS)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             pwr_down,
   input logic             chg_off,
   input logic             pwr_up,
   input logic             in_off,
   input logic [CNT_W-1:0] hold_cnt
);
   // R4
   down_enters_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      chg_off |-> in_off);

   // R4
   down_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_down |=> !pwr_down);

   // R6
   up_leaves_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_up |-> !in_off);

   // R6
   up_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pwr_up |=> !pwr_up);

   // R7
   no_down_up_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({pwr_down, pwr_up}));

   // R7
   off_count_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      in_off |-> (hold_cnt == '0));

   // R5
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hold_cnt < CNT_W'(HOLD_TICKS));
endmodule

bind longpress_restart longpress_restart_chk #(.HOLD_TICKS(HOLD_TICKS)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .pwr_down (pwr_down),
   .chg_off  (chg_off),
   .pwr_up   (pwr_up),
   .in_off   (in_off),
   .hold_cnt (hold_cnt)
);

// File: tb/sim_longpress_restart.sv
`timescale 1ns/1ps
module sim_longpress_restart;
   localparam int H   = 40;
   localparam int S   = 2;
   localparam bit DEF = 1'b1;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic btn_n = 1'b1;
   logic cfg_we = 1'b0;
   logic cfg_off = 1'b0;
   logic pwr_down, chg_off, reg_clr, pwr_up, btn_pass_n;

   always #2 clk = ~clk;

   longpress_restart #(.HOLD_TICKS(H), .SYNC_STAGES(S), .OFF_AT_RESET(DEF)) u0 (
      .clk(clk), .rst_n(rst_n), .btn_n(btn_n), .cfg_we(cfg_we), .cfg_off(cfg_off),
      .pwr_down(pwr_down), .chg_off(chg_off), .reg_clr(reg_clr),
      .pwr_up(pwr_up), .btn_pass_n(btn_pass_n)
   );

   int checks = 0;
   int fails = 0;
   int cyc = 0;

   // behavioural reference model
   bit hist[$];
   bit m_off;
   bit m_held;
   int m_cnt;
   bit e_dn, e_up;

   initial begin
      for (int i = 0; i < S; i++) hist.push_back(1'b0);
      m_off = DEF;
      m_held = 0;
      m_cnt = 0;
      e_dn = 0;
      e_up = 0;
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < S; i++) hist[i] = 1'b0;
         m_off = DEF; m_held = 0; m_cnt = 0; e_dn = 0; e_up = 0;
      end else begin
         bit p;
         bit fire;
         p = hist[S-1];
         fire = 0;
         e_up = 0;
         if (m_held) begin
            if (!p) begin e_up = 1; m_held = 0; end
         end else if (p && !m_off) begin
            if (m_cnt == H-1) begin fire = 1; m_held = 1; m_cnt = 0; end
            else m_cnt++;
         end else begin
            m_cnt = 0;
         end
         e_dn = fire;
         if (fire) m_off = DEF;
         else if (cfg_we) m_off = cfg_off;
         hist.push_front(!btn_n);
         void'(hist.pop_back());
      end
   end

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s cycle=%0d actual=%0d expected=%0d", tag, cyc, act, exp);
      end
   endtask

   int n_dn = 0, n_up = 0, dn_at = 0, up_at = 0;

   always @(posedge clk) begin
      cyc++;
      #1;
      if (!rst_n) begin
         chk({pwr_down, chg_off, reg_clr, pwr_up} == 4'b0, "R1 strobes in reset",
             {pwr_down, chg_off, reg_clr, pwr_up}, 0);
         chk(btn_pass_n == 1'b1, "R1 pass in reset", btn_pass_n, 1);
      end else begin
         chk(pwr_down == e_dn, "R4 pwr_down", pwr_down, e_dn);
         chk(chg_off == e_dn, "R4 chg_off", chg_off, e_dn);
         chk(reg_clr == e_dn, "R4 reg_clr", reg_clr, e_dn);
         chk(pwr_up == e_up, "R6 pwr_up", pwr_up, e_up);
         chk(btn_pass_n == (!hist[S-1] || m_held), "R8 R9 btn_pass_n",
             btn_pass_n, (!hist[S-1] || m_held));
         if (pwr_down) begin n_dn++; dn_at = cyc; end
         if (pwr_up) begin n_up++; up_at = cyc; end
      end
   end

   task automatic finish_run();
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   always @(posedge clk) begin
      if (cyc > 20000) begin
         fails++;
         checks++;
         $display("FAIL watchdog cycle=%0d actual=%0d expected=%0d", cyc, cyc, 20000);
         finish_run();
      end
   end

   task automatic wait_cyc(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic press(input int n);
      btn_n = 1'b0;
      wait_cyc(n);
      btn_n = 1'b1;
   endtask

   task automatic wr(input bit v);
      cfg_we = 1'b1;
      cfg_off = v;
      wait_cyc(1);
      cfg_we = 1'b0;
   endtask

   task automatic clear_tally();
      n_dn = 0; n_up = 0;
   endtask

   initial begin
      wait_cyc(5);
      rst_n = 1'b1;
      wait_cyc(3);

      // R3: default disable bit is 1, a long hold does nothing
      clear_tally();
      press(60);
      wait_cyc(6);
      chk(n_dn == 0, "R3 default disables restart", n_dn, 0);

      // R9: synchronizer latency
      wr(1'b0);
      btn_n = 1'b0;
      @(posedge clk); #1;
      chk(btn_pass_n == 1'b1, "R9 after one edge", btn_pass_n, 1);
      @(posedge clk); #1;
      chk(btn_pass_n == 1'b0, "R9 after two edges", btn_pass_n, 0);
      @(negedge clk);
      btn_n = 1'b1;
      wait_cyc(5);

      // short press: ordinary activity only
      clear_tally();
      press(10);
      wait_cyc(5);
      chk(n_dn == 0, "R8 short press no restart", n_dn, 0);

      // R5: two presses just below threshold
      clear_tally();
      press(H-1);
      wait_cyc(1);
      press(H-1);
      wait_cyc(6);
      chk(n_dn == 0, "R5 count cleared on release", n_dn, 0);

      // R4: exactly the threshold
      clear_tally();
      press(H);
      wait_cyc(6);
      chk(n_dn == 1, "R4 fires at threshold", n_dn, 1);
      chk(up_at - dn_at == 1, "R6 zero extra gap", up_at - dn_at, 1);

      // R10: restart returned the bit to its default (1)
      clear_tally();
      press(60);
      wait_cyc(6);
      chk(n_dn == 0, "R10 bit back at default", n_dn, 0);

      // R6: off time tracks extra hold
      wr(1'b0);
      clear_tally();
      press(H + 15);
      wait_cyc(6);
      chk(n_dn == 1 && n_up == 1, "R6 one down one up", n_dn * 10 + n_up, 11);
      chk(up_at - dn_at == 16, "R6 gap equals extra hold plus one", up_at - dn_at, 16);

      // R7: very long hold with a write while held off
      wr(1'b0);
      clear_tally();
      btn_n = 1'b0;
      wait_cyc(60);
      wr(1'b1);
      wait_cyc(69);
      btn_n = 1'b1;
      wait_cyc(6);
      chk(n_dn == 1, "R7 single restart on long hold", n_dn, 1);
      chk(n_up == 1, "R7 power-up despite write", n_up, 1);

      // R2: explicit disable
      wr(1'b0);
      wr(1'b1);
      clear_tally();
      press(100);
      wait_cyc(6);
      chk(n_dn == 0, "R2 disabled blocks restart", n_dn, 0);

      finish_run();
   end
endmodule